// File: doc/BRIEF.md
# Two-Product Drink Vending Controller

This block is the control core of a drink dispenser offering coffee and tea. Customers insert one-, two- and five-dollar coins, each reported to the block as a single-clock pulse on its own input. The block adds every accepted coin to a stored credit. A select input picks the product, and therefore the price. As soon as the credit covers that price, the block issues a one-cycle dispense pulse.

Any overpayment goes back to the customer as a series of change pulses, one per clock. Two-dollar pulses are issued while at least two dollars remain, then one-dollar pulses. After the last pulse the controller clears its credit and waits for the next customer. Coin pulses that arrive while a sale is being completed are discarded. A synchronous reset returns the block to an empty, quiet idle state from any point in a sale.

Top module: `drink_vend_ctrl`

## Requirements
- R1: After a synchronous reset all three outputs are low and the credit is zero, so a following one-dollar coin alone produces no dispense pulse.
- R2: While idle, coins add to the credit across cycles with values $1 (coin1_i), $2 (coin2_i) and $5 (coin5_i); a dispense happens only once the accumulated sum covers the price.
- R3: When several coin inputs are high in the same cycle, only the highest denomination among them is added.
- R4: sel_i = 1 selects coffee at $3 and sel_i = 0 selects tea at $2. The price compared is the one selected in the cycle the credit first covers it, and a change of sel_i alone can complete a sale.
- R5: vend_o is high for exactly one cycle. It rises in the cycle after the clock edge at which the credit first covers the price.
- R6: The excess is paid back one pulse per cycle, starting in the cycle right after the dispense pulse. chg2_o pulses come while $2 or more remains, then a chg1_o pulse if $1 remains. At most one of vend_o, chg1_o and chg2_o is high in any cycle.
- R7: Coin inputs that are high during the dispense cycle or the change cycles are ignored and do not change the change sequence.
- R8: When the change sequence ends (or right after the dispense pulse when there is no excess), the credit is zero and the block is idle again.
- R9: Asserting the synchronous reset in the middle of a dispense or change sequence abandons it: every output is low in the next cycle, and no credit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Product select: 1 coffee, 0 tea |
| coin1_i | input | 1 | One-cycle pulse for a one-dollar coin |
| coin2_i | input | 1 | One-cycle pulse for a two-dollar coin |
| coin5_i | input | 1 | One-cycle pulse for a five-dollar coin |
| vend_o | output | 1 | One-cycle dispense pulse |
| chg1_o | output | 1 | One-dollar change pulse |
| chg2_o | output | 1 | Two-dollar change pulse |

## Verification
A coin or select change that completes a sale is registered at one rising edge, and vend_o is read just after that edge. Each change pulse then follows exactly one cycle after the one before it. After the last pulse comes a single all-low cycle that marks the return to idle. The bench drives inputs at the falling edge and samples one time unit after each rising edge. Each scenario compares the outputs in every cycle against a pulse pattern computed from the price and the coins paid, so an early, late, missing or extra pulse is reported in the cycle where it occurs. Scenarios that test ignoring and clearing follow up with a one-dollar coin and confirm that no dispense results.

// File: rtl/drink_vend_pkg.sv
package drink_vend_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VEND   = 2'd1,
        ST_CHANGE = 2'd2
    } vend_state_e;

endpackage

// File: rtl/dv_coin_value.sv
module dv_coin_value #(
    parameter int CREDIT_W = 4,
    parameter int VAL_LO   = 1,
    parameter int VAL_MID  = 2,
    parameter int VAL_HI   = 5
) (
    input  logic                coin_lo_i,
    input  logic                coin_mid_i,
    input  logic                coin_hi_i,
    output logic [CREDIT_W-1:0] value_o
);
    localparam logic [CREDIT_W-1:0] LO_W  = CREDIT_W'(VAL_LO);
    localparam logic [CREDIT_W-1:0] MID_W = CREDIT_W'(VAL_MID);
    localparam logic [CREDIT_W-1:0] HI_W  = CREDIT_W'(VAL_HI);

    // Highest denomination wins when several pulses coincide.
    always_comb begin
        if (coin_hi_i) begin
            value_o = HI_W;
        end else if (coin_mid_i) begin
            value_o = MID_W;
        end else if (coin_lo_i) begin
            value_o = LO_W;
        end else begin
            value_o = '0;
        end
    end

endmodule

// File: rtl/dv_price_sel.sv
module dv_price_sel #(
    parameter int CREDIT_W     = 4,
    parameter int TEA_PRICE    = 2,
    parameter int COFFEE_PRICE = 3
) (
    input  logic                sel_coffee_i,
    output logic [CREDIT_W-1:0] price_o
);
    localparam logic [CREDIT_W-1:0] TEA_W    = CREDIT_W'(TEA_PRICE);
    localparam logic [CREDIT_W-1:0] COFFEE_W = CREDIT_W'(COFFEE_PRICE);

    always_comb begin
        price_o = sel_coffee_i ? COFFEE_W : TEA_W;
    end

endmodule

// File: rtl/dv_change_step.sv
module dv_change_step #(
    parameter int CREDIT_W = 4
) (
    input  logic [CREDIT_W-1:0] rem_i,
    output logic                give2_o,
    output logic                give1_o,
    output logic [CREDIT_W-1:0] rem_next_o
);
    localparam logic [CREDIT_W-1:0] TWO = CREDIT_W'(2);
    localparam logic [CREDIT_W-1:0] ONE = CREDIT_W'(1);

    always_comb begin
        give2_o    = 1'b0;
        give1_o    = 1'b0;
        rem_next_o = rem_i;
        if (rem_i >= TWO) begin
            give2_o    = 1'b1;
            rem_next_o = rem_i - TWO;
        end else if (rem_i != '0) begin
            give1_o    = 1'b1;
            rem_next_o = rem_i - ONE;
        end
    end

endmodule

// File: rtl/drink_vend_ctrl.sv
module drink_vend_ctrl #(
    parameter int CREDIT_W     = 4,
    parameter int TEA_PRICE    = 2,
    parameter int COFFEE_PRICE = 3,
    parameter int COIN_LO      = 1,
    parameter int COIN_MID     = 2,
    parameter int COIN_HI      = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic coin1_i,
    input  logic coin2_i,
    input  logic coin5_i,
    output logic vend_o,
    output logic chg1_o,
    output logic chg2_o
);
    import drink_vend_pkg::*;

    localparam int MAX_PRICE = (TEA_PRICE > COFFEE_PRICE) ? TEA_PRICE : COFFEE_PRICE;
    localparam logic [CREDIT_W-1:0] MAX_PRICE_W = CREDIT_W'(MAX_PRICE);

    typedef struct packed {
        vend_state_e         state;
        logic [CREDIT_W-1:0] credit;
        logic [CREDIT_W-1:0] rem;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{state: ST_IDLE, credit: '0, rem: '0};

    ctrl_t ctrl_d, ctrl_q;

    logic [CREDIT_W-1:0] coin_val;
    logic [CREDIT_W-1:0] price;
    logic [CREDIT_W-1:0] sum;
    logic                give2, give1;
    logic [CREDIT_W-1:0] rem_next;

    dv_coin_value #(
        .CREDIT_W (CREDIT_W),
        .VAL_LO   (COIN_LO),
        .VAL_MID  (COIN_MID),
        .VAL_HI   (COIN_HI)
    ) u_coin (
        .coin_lo_i  (coin1_i),
        .coin_mid_i (coin2_i),
        .coin_hi_i  (coin5_i),
        .value_o    (coin_val)
    );

    dv_price_sel #(
        .CREDIT_W     (CREDIT_W),
        .TEA_PRICE    (TEA_PRICE),
        .COFFEE_PRICE (COFFEE_PRICE)
    ) u_price (
        .sel_coffee_i (sel_i),
        .price_o      (price)
    );

    dv_change_step #(
        .CREDIT_W (CREDIT_W)
    ) u_step (
        .rem_i      (ctrl_q.rem),
        .give2_o    (give2),
        .give1_o    (give1),
        .rem_next_o (rem_next)
    );

    assign sum = ctrl_q.credit + coin_val;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (sum >= price) begin
                    ctrl_d.state  = ST_VEND;
                    ctrl_d.rem    = sum - price;
                    ctrl_d.credit = '0;
                end else begin
                    ctrl_d.credit = sum;
                end
            end
            ST_VEND: begin
                ctrl_d.state = (ctrl_q.rem == '0) ? ST_IDLE : ST_CHANGE;
            end
            ST_CHANGE: begin
                ctrl_d.rem = rem_next;
                if (rem_next == '0) begin
                    ctrl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctrl_d = CTRL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign vend_o = (ctrl_q.state == ST_VEND);
    assign chg2_o = (ctrl_q.state == ST_CHANGE) && give2;
    assign chg1_o = (ctrl_q.state == ST_CHANGE) && give1;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!vend_o && !chg1_o && !chg2_o)) else $error("AST_RESET_QUIET"); // R9

    AST_VEND_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vend_o |=> !vend_o) else $error("AST_VEND_SINGLE"); // R5

    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vend_o, chg1_o, chg2_o})) else $error("AST_OUT_EXCL"); // R6

    AST_ONE_LAST: assert property (@(posedge clk) disable iff (rst)
        chg1_o |=> (!chg1_o && !chg2_o)) else $error("AST_ONE_LAST"); // R6

    AST_CHANGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (vend_o || chg2_o) |=> (chg1_o || chg2_o || ctrl_q.state == ST_IDLE)) else $error("AST_CHANGE_FOLLOWS"); // R6

    AST_IDLE_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.state == ST_IDLE) |-> (ctrl_q.credit < MAX_PRICE_W)) else $error("AST_IDLE_CREDIT_BOUND"); // R2

    AST_CREDIT_CLEAR_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.state != ST_IDLE) |-> (ctrl_q.credit == '0)) else $error("AST_CREDIT_CLEAR_BUSY"); // R8

endmodule

// File: tb/drink_vend_ctrl_tb.sv
module drink_vend_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_i = 1'b0;
    logic coin1_i = 1'b0;
    logic coin2_i = 1'b0;
    logic coin5_i = 1'b0;
    logic vend_o, chg1_o, chg2_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    drink_vend_ctrl u_dut (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel_i),
        .coin1_i (coin1_i),
        .coin2_i (coin2_i),
        .coin5_i (coin5_i),
        .vend_o  (vend_o),
        .chg1_o  (chg1_o),
        .chg2_o  (chg2_o)
    );

    task automatic check_out(input string req, input logic ev, input logic e1, input logic e2);
        checks++;
        if (vend_o !== ev || chg1_o !== e1 || chg2_o !== e2) begin
            failures++;
            $display("FAIL %s: vend/chg1/chg2 actual=%b%b%b expected=%b%b%b",
                     req, vend_o, chg1_o, chg2_o, ev, e1, e2);
        end
    endtask

    // Drive coins for one cycle; returns 1 time unit after the sampling edge.
    task automatic put_coin(input logic c1, input logic c2, input logic c5);
        @(negedge clk);
        coin1_i = c1; coin2_i = c2; coin5_i = c5;
        @(posedge clk);
        #1;
        coin1_i = 1'b0; coin2_i = 1'b0; coin5_i = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    // Called right after the completing edge: expects vend now, then change pulses, then idle.
    task automatic expect_sale(input string req, input int n2, input int n1);
        check_out(req, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < n2; i++) begin
            next_cycle();
            check_out(req, 1'b0, 1'b0, 1'b1);
        end
        for (int i = 0; i < n1; i++) begin
            next_cycle();
            check_out(req, 1'b0, 1'b1, 1'b0);
        end
        next_cycle();
        check_out(req, 1'b0, 1'b0, 1'b0);
    endtask

    // A lone $1 must not complete a sale if credit is really zero; then drain it.
    task automatic probe_empty(input string req);
        sel_i = 1'b0;
        put_coin(1'b1, 1'b0, 1'b0);
        check_out(req, 1'b0, 1'b0, 1'b0);
        do_reset();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check_out("R1", 1'b0, 1'b0, 1'b0);
        probe_empty("R1");
    endtask

    task automatic t_tea_exact();
        sel_i = 1'b0;
        put_coin(1'b0, 1'b1, 1'b0);
        expect_sale("R5", 0, 0);
        probe_empty("R8");
    endtask

    task automatic t_coffee_ones();
        sel_i = 1'b1;
        put_coin(1'b1, 1'b0, 1'b0);
        check_out("R2", 1'b0, 1'b0, 1'b0);
        put_coin(1'b1, 1'b0, 1'b0);
        check_out("R2", 1'b0, 1'b0, 1'b0);
        put_coin(1'b1, 1'b0, 1'b0);
        expect_sale("R2", 0, 0);
    endtask

    task automatic t_tea_five();
        sel_i = 1'b0;
        put_coin(1'b0, 1'b0, 1'b1);
        expect_sale("R6", 1, 1);
        probe_empty("R8");
    endtask

    task automatic t_coffee_seven();
        sel_i = 1'b1;
        put_coin(1'b0, 1'b1, 1'b0);
        check_out("R4", 1'b0, 1'b0, 1'b0);
        put_coin(1'b0, 1'b0, 1'b1);
        expect_sale("R6", 2, 0);
    endtask

    task automatic t_priority();
        sel_i = 1'b1;
        put_coin(1'b1, 1'b1, 1'b1);
        expect_sale("R3", 1, 0);
        sel_i = 1'b0;
        put_coin(1'b1, 1'b1, 1'b0);
        expect_sale("R3", 0, 0);
    endtask

    task automatic t_ignore_busy();
        sel_i = 1'b0;
        put_coin(1'b0, 1'b0, 1'b1);
        check_out("R7", 1'b1, 1'b0, 1'b0);
        put_coin(1'b0, 1'b0, 1'b1);
        check_out("R7", 1'b0, 1'b0, 1'b1);
        put_coin(1'b1, 1'b1, 1'b0);
        check_out("R7", 1'b0, 1'b1, 1'b0);
        next_cycle();
        check_out("R7", 1'b0, 1'b0, 1'b0);
        probe_empty("R7");
    endtask

    task automatic t_sel_late();
        sel_i = 1'b1;
        put_coin(1'b0, 1'b1, 1'b0);
        check_out("R4", 1'b0, 1'b0, 1'b0);
        next_cycle();
        check_out("R4", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        sel_i = 1'b0;
        next_cycle();
        expect_sale("R4", 0, 0);
    endtask

    task automatic t_reset_mid();
        sel_i = 1'b1;
        put_coin(1'b0, 1'b1, 1'b0);
        put_coin(1'b0, 1'b0, 1'b1);
        check_out("R9", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        next_cycle();
        check_out("R9", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        next_cycle();
        check_out("R9", 1'b0, 1'b0, 1'b0);
        probe_empty("R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        t_tea_exact();
        t_coffee_ones();
        t_tea_five();
        t_coffee_seven();
        t_priority();
        t_ignore_busy();
        t_sel_late();
        t_reset_mid();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule